// File: doc/BRIEF.md
# Polled PIO Sector Read Engine

This block is the host-side sequencer for a programmed-I/O read of a run of sectors from a disk drive's task-file registers. A start request carries a sector count, a sectors-per-block value and a mode flag. The engine writes the matching read opcode to the command register and waits a settle interval. It then polls the status register until the drive reports data ready. It then streams the data register contents, one 16-bit word per read, out of a valid/ready port. Address setup is done beforehand by a separate loader, so this engine only touches the command/status register (address 7) and the data register (address 0).

In one-sector mode every sector needs its own data-ready phase. In block mode one phase delivers a whole block of sectors. The last block may be shorter, and the engine then moves only what remains. After the command write, and after the final word of every phase that is not the last, the engine stays off the bus for a settle window before it polls again. This lets the drive drop its data-request flag and, if needed, raise its busy flag. An error flag seen while polling aborts the run. When the run finishes, the engine gives a one-cycle done or error pulse.

Top module: `pio_rd_engine`

## Requirements
- R1: Out of reset, busy_o, done_o, err_o, out_valid_o, tf_rd_o and tf_wr_o are all low.
- R2: A start accepted in idle with a non-zero count writes one opcode to address 7 for one cycle: 0x20 when multi_i is 0, 0xC4 when multi_i is 1.
- R3: Status is read from address 7. When bit 7 (busy) is set, every other bit is ignored and polling continues. With bit 7 clear, bit 0 (error) aborts the run. Otherwise bit 3 (data request) starts a data phase. A status with none of these bits set keeps the engine polling.
- R4: Each sector is 256 words read from address 0. Every word read appears once on out_data_o, in read order.
- R5: In one-sector mode each data phase carries exactly one sector, so a run of N sectors takes N data-ready polls.
- R6: In block mode a phase carries the smaller of the block size and the sectors still remaining. A block size of 0 counts as 1.
- R7: The first status read after the command write, and after the last word of a non-final phase, comes exactly SETTLE_CYC+1 cycles later. SETTLE_CYC is the ceiling of SETTLE_PS/CLK_PERIOD_PS (40 by default).
- R8: The data register is read only in a cycle where out_ready_i is high. A stalled stream loses and repeats no word.
- R9: done_o pulses for one cycle in the cycle after the final word is accepted. err_o pulses for one cycle in the cycle after the status read that showed the error. A start with count 0 writes no command and pulses done_o.
- R10: A start while a run is in progress is ignored: the run keeps its original count and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, sampled in idle |
| sec_count_i | input | CNT_W | Sectors to read |
| blk_size_i | input | BLK_W | Sectors per data phase in block mode |
| multi_i | input | 1 | 1 = block mode, 0 = one sector per phase |
| tf_addr_o | output | 3 | Task-file register address |
| tf_rd_o | output | 1 | Register read strobe |
| tf_wr_o | output | 1 | Register write strobe |
| tf_wdata_o | output | 8 | Register write data |
| tf_rdata_i | input | 16 | Register read data, valid in the strobe cycle |
| out_valid_o | output | 1 | Stream word valid |
| out_data_o | output | 16 | Stream word |
| out_ready_i | input | 1 | Stream consumer ready |
| busy_o | output | 1 | Engine not idle |
| done_o | output | 1 | Run completed pulse |
| err_o | output | 1 | Run aborted pulse |

## Verification
The command strobe follows the start cycle by one cycle. The first poll comes SETTLE_CYC+1 cycles after the command write or after a phase's last word. Done or error follows the final word or the failing poll by exactly one cycle. The bench's drive model and stream sink record the clock edge at which each bus event happens and compare the distances between events against these figures, not absolute times, so backpressure patterns do not move the expected values. Word order is checked against a running sequence counter shared by the model and the sink, and phase and word totals are compared once each run's end pulse arrives.

// File: rtl/pio_rd_pkg.sv
package pio_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_SETTLE,
        ST_POLL,
        ST_XFER,
        ST_DONE,
        ST_FAIL
    } pio_state_e;

    localparam logic [7:0] OPC_READ_ONE   = 8'h20;
    localparam logic [7:0] OPC_READ_BLOCK = 8'hC4;

    localparam logic [2:0] REG_DATA    = 3'd0;
    localparam logic [2:0] REG_CMDSTAT = 3'd7;

    localparam int STAT_BUSY_BIT = 7;
    localparam int STAT_DREQ_BIT = 3;
    localparam int STAT_FAIL_BIT = 0;

endpackage

// File: rtl/pio_settle_timer.sv
module pio_settle_timer #(
    parameter int CYC = 40
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    output logic expired_o
);
    localparam int TW = (CYC < 2) ? 1 : $clog2(CYC + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = TW'(CYC - 1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - TW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    // R7: once run out, the window stays closed until reloaded
    a_r7_timer_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (expired_o && !load_i) |=> expired_o);

endmodule

// File: rtl/pio_word_cnt.sv
module pio_word_cnt #(
    parameter int WORDS = 256
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic adv_i,
    output logic last_o
);
    localparam int WW = (WORDS < 2) ? 1 : $clog2(WORDS);

    logic [WW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (adv_i) begin
            cnt_d = last_o ? '0 : cnt_q + WW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == WW'(WORDS - 1));

    // R4: after a sector's final word the next word starts a fresh sector
    a_r4_sector_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && last_o && !clr_i) |=> !last_o || (WORDS == 1));

endmodule

// File: rtl/pio_rd_engine.sv
module pio_rd_engine
    import pio_rd_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 10000,
    parameter int SETTLE_PS     = 400000,
    parameter int CNT_W         = 16,
    parameter int BLK_W         = 8,
    parameter int WORDS_PER_SEC = 256
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [CNT_W-1:0] sec_count_i,
    input  logic [BLK_W-1:0] blk_size_i,
    input  logic             multi_i,
    output logic [2:0]       tf_addr_o,
    output logic             tf_rd_o,
    output logic             tf_wr_o,
    output logic [7:0]       tf_wdata_o,
    input  logic [15:0]      tf_rdata_i,
    output logic             out_valid_o,
    output logic [15:0]      out_data_o,
    input  logic             out_ready_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o
);
    localparam int SETTLE_CYC = (SETTLE_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;

    typedef struct packed {
        pio_state_e       st;
        logic [CNT_W-1:0] remain;
        logic [CNT_W-1:0] phase_left;
        logic [BLK_W-1:0] blk;
        logic             multi;
    } eng_s;

    eng_s eng_d, eng_q;

    logic             tmr_load, tmr_expired;
    logic             wc_clr, wc_adv, wc_last;
    logic [CNT_W-1:0] blk_eff, phase_sz;

    pio_settle_timer #(.CYC(SETTLE_CYC)) settle_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (tmr_load),
        .expired_o (tmr_expired)
    );

    pio_word_cnt #(.WORDS(WORDS_PER_SEC)) words_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (wc_clr),
        .adv_i  (wc_adv),
        .last_o (wc_last)
    );

    always_comb begin
        blk_eff  = (eng_q.blk == '0) ? CNT_W'(1) : CNT_W'(eng_q.blk);
        phase_sz = CNT_W'(1);
        if (eng_q.multi) begin
            phase_sz = (eng_q.remain < blk_eff) ? eng_q.remain : blk_eff;
        end
    end

    always_comb begin
        eng_d       = eng_q;
        tf_addr_o   = REG_DATA;
        tf_rd_o     = 1'b0;
        tf_wr_o     = 1'b0;
        tf_wdata_o  = '0;
        out_valid_o = 1'b0;
        done_o      = 1'b0;
        err_o       = 1'b0;
        tmr_load    = 1'b0;
        wc_clr      = 1'b0;
        wc_adv      = 1'b0;

        unique case (eng_q.st)
            ST_IDLE: begin
                wc_clr = 1'b1;
                if (start_i) begin
                    eng_d.remain = sec_count_i;
                    eng_d.blk    = blk_size_i;
                    eng_d.multi  = multi_i;
                    eng_d.st     = (sec_count_i == '0) ? ST_DONE : ST_CMD;
                end
            end
            ST_CMD: begin
                tf_wr_o    = 1'b1;
                tf_addr_o  = REG_CMDSTAT;
                tf_wdata_o = eng_q.multi ? OPC_READ_BLOCK : OPC_READ_ONE;
                tmr_load   = 1'b1;
                eng_d.st   = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (tmr_expired) eng_d.st = ST_POLL;
            end
            ST_POLL: begin
                tf_rd_o   = 1'b1;
                tf_addr_o = REG_CMDSTAT;
                if (tf_rdata_i[STAT_BUSY_BIT]) begin
                    eng_d.st = ST_POLL;
                end else if (tf_rdata_i[STAT_FAIL_BIT]) begin
                    eng_d.st = ST_FAIL;
                end else if (tf_rdata_i[STAT_DREQ_BIT]) begin
                    eng_d.phase_left = phase_sz;
                    eng_d.st         = ST_XFER;
                end
            end
            ST_XFER: begin
                out_valid_o = 1'b1;
                tf_addr_o   = REG_DATA;
                tf_rd_o     = out_ready_i;
                if (out_ready_i) begin
                    wc_adv = 1'b1;
                    if (wc_last) begin
                        eng_d.remain     = eng_q.remain - CNT_W'(1);
                        eng_d.phase_left = eng_q.phase_left - CNT_W'(1);
                        if (eng_q.remain == CNT_W'(1)) begin
                            eng_d.st = ST_DONE;
                        end else if (eng_q.phase_left == CNT_W'(1)) begin
                            tmr_load = 1'b1;
                            eng_d.st = ST_SETTLE;
                        end
                    end
                end
            end
            ST_DONE: begin
                done_o   = 1'b1;
                eng_d.st = ST_IDLE;
            end
            ST_FAIL: begin
                err_o    = 1'b1;
                eng_d.st = ST_IDLE;
            end
            default: eng_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            eng_q    <= '0;
            eng_q.st <= ST_IDLE;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign out_data_o = tf_rdata_i;
    assign busy_o     = (eng_q.st != ST_IDLE);

    // R2: the only register write is a read opcode to the command register
    a_r2_opcode_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tf_wr_o |-> (tf_addr_o == REG_CMDSTAT) &&
                    (tf_wdata_o == OPC_READ_ONE || tf_wdata_o == OPC_READ_BLOCK));

    // R3: a busy status keeps the engine polling
    a_r3_busy_keeps_polling: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tf_rd_o && tf_addr_o == REG_CMDSTAT && tf_rdata_i[STAT_BUSY_BIT]) |=>
        (tf_rd_o && tf_addr_o == REG_CMDSTAT));

    // R3: never read and write the register file in the same cycle
    a_r3_no_rd_wr_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(tf_rd_o && tf_wr_o));

    // R8: data register reads only when the consumer takes the word
    a_r8_read_needs_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tf_rd_o && tf_addr_o == REG_DATA) |-> (out_valid_o && out_ready_i));

    // R8: a stalled word stays offered
    a_r8_valid_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && !out_ready_i) |=> out_valid_o);

    // R7: polling resumes only once the settle window has run out
    a_r7_poll_after_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eng_q.st == ST_POLL && $past(eng_q.st) == ST_SETTLE) |-> $past(tmr_expired));

    // R9: completion and abort never coincide
    a_r9_done_err_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(done_o && err_o));

    // R9: end pulses last a single cycle
    a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o || err_o) |=> !(done_o || err_o));

endmodule

// File: tb/pio_rd_engine_tb_top.sv
module pio_rd_engine_tb_top;

    localparam int SETTLE_CYC = 40;
    localparam int WPS        = 256;

    typedef struct packed {
        logic [15:0] cnt;
        logic [7:0]  blk;
        logic        multi;
        logic [1:0]  rdy;
        logic [7:0]  errp;
    } vec_t;

    // count, block, mode, ready pattern, phase that reports error (FF = none)
    localparam vec_t VECS [9] = '{
        '{16'd1, 8'd0, 1'b0, 2'd0, 8'hFF},
        '{16'd3, 8'd0, 1'b0, 2'd1, 8'hFF},
        '{16'd5, 8'd2, 1'b1, 2'd0, 8'hFF},
        '{16'd4, 8'd4, 1'b1, 2'd2, 8'hFF},
        '{16'd3, 8'd0, 1'b1, 2'd0, 8'hFF},
        '{16'd2, 8'd0, 1'b0, 2'd0, 8'd1},
        '{16'd0, 8'd3, 1'b1, 2'd0, 8'hFF},
        '{16'd2, 8'd8, 1'b1, 2'd1, 8'hFF},
        '{16'd3, 8'd2, 1'b1, 2'd0, 8'd0}
    };

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] sec_count_i = '0;
    logic [7:0]  blk_size_i = '0;
    logic        multi_i = 1'b0;
    logic [2:0]  tf_addr_o;
    logic        tf_rd_o, tf_wr_o;
    logic [7:0]  tf_wdata_o;
    logic [15:0] tf_rdata_i;
    logic        out_valid_o;
    logic [15:0] out_data_o;
    logic        out_ready_i = 1'b1;
    logic        busy_o, done_o, err_o;

    always #5 clk_i = ~clk_i;

    pio_rd_engine dut_i (
        .clk_i, .rst_ni, .start_i, .sec_count_i, .blk_size_i, .multi_i,
        .tf_addr_o, .tf_rd_o, .tf_wr_o, .tf_wdata_o, .tf_rdata_i,
        .out_valid_o, .out_data_o, .out_ready_i, .busy_o, .done_o, .err_o
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [15:0] cfg_cnt = '0;
    logic [7:0]  cfg_blk = '0, cfg_errp = 8'hFF;
    logic        cfg_multi = 1'b0;
    logic [1:0]  cfg_rdy = '0;

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int imin(int a, int b);
        return (a < b) ? a : b;
    endfunction

    always @(negedge clk_i) begin
        cyc <= cyc + 1;
        case (cfg_rdy)
            2'd1:    out_ready_i <= cyc[0];
            2'd2:    out_ready_i <= (cyc % 3) != 0;
            default: out_ready_i <= 1'b1;
        endcase
    end

    // drive model
    logic        m_active = 1'b0, m_drq = 1'b0;
    int          m_busy = 0, m_phase = 0, m_sec = 0, m_word = 0, m_rem = 0;
    logic [15:0] m_val = 16'h1000, exp_val = 16'h1000;
    logic [7:0]  m_stat, cmd_byte = '0;
    int cmd_cnt = 0, phases = 0, proto_err = 0, gap_err = 0, gap_seen = 0;
    int evt_cyc = 0, last_poll = 0, words = 0, seq_err = 0, last_word_cyc = 0;
    int done_cnt = 0, err_cnt = 0, done_cyc = 0, err_cyc = 0;
    logic gap_pend = 1'b0;

    always_comb begin
        if (!m_active)         m_stat = 8'h40;
        else if (m_drq)        m_stat = 8'h48;
        else if (m_busy > 1)   m_stat = 8'h88;
        else if (m_busy == 1)  m_stat = 8'h40;
        else if (m_phase == int'(cfg_errp)) m_stat = 8'h41;
        else                   m_stat = 8'h48;
        tf_rdata_i = (tf_addr_o == 3'd7) ? {8'h00, m_stat} : m_val;
    end

    always @(posedge clk_i) begin
        if (rst_ni && tf_wr_o && tf_addr_o == 3'd7) begin
            cmd_byte <= tf_wdata_o; cmd_cnt <= cmd_cnt + 1;
            m_active <= 1'b1; m_drq <= 1'b0; m_busy <= 3; m_phase <= 0;
            m_rem <= int'(cfg_cnt); m_word <= 0; gap_pend <= 1'b1; evt_cyc <= cyc;
        end
        if (rst_ni && tf_rd_o && tf_addr_o == 3'd7) begin
            last_poll <= cyc;
            if (gap_pend) begin
                gap_seen <= gap_seen + 1;
                if (cyc - evt_cyc != SETTLE_CYC + 1) gap_err <= gap_err + 1;
                gap_pend <= 1'b0;
            end
            if (m_active && !m_drq) begin
                if (m_busy > 0) m_busy <= m_busy - 1;
                else if (m_phase != int'(cfg_errp)) begin
                    m_drq <= 1'b1; phases <= phases + 1;
                    m_sec <= cfg_multi ? imin((cfg_blk == 0) ? 1 : int'(cfg_blk), m_rem) : 1;
                end
            end
        end
        if (rst_ni && tf_rd_o && tf_addr_o == 3'd0) begin
            if (!m_drq) proto_err <= proto_err + 1;
            else begin
                m_val <= m_val + 16'd1;
                if (m_word == WPS - 1) begin
                    m_word <= 0; m_rem <= m_rem - 1; m_sec <= m_sec - 1;
                    if (m_sec == 1) begin
                        m_drq <= 1'b0; m_phase <= m_phase + 1; m_busy <= 2;
                        gap_pend <= 1'b1; evt_cyc <= cyc;
                    end
                end else m_word <= m_word + 1;
            end
        end
        if (rst_ni && out_valid_o && out_ready_i) begin
            if (out_data_o != exp_val) seq_err <= seq_err + 1;
            exp_val <= exp_val + 16'd1; words <= words + 1; last_word_cyc <= cyc;
        end
        if (rst_ni && done_o) begin done_cnt <= done_cnt + 1; done_cyc <= cyc; end
        if (rst_ni && err_o)  begin err_cnt  <= err_cnt + 1;  err_cyc  <= cyc; end
    end

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    always @(negedge clk_i) begin
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            finish_run();
        end
    end

    task automatic wait_end(int d0, int e0);
        for (int t = 0; t < 30000; t++) begin
            @(negedge clk_i);
            if (done_cnt != d0 || err_cnt != e0) break;
        end
        repeat (3) @(negedge clk_i);
    endtask

    task automatic run_vec(vec_t v);
        int c0, p0, w0, d0, e0, ge0, gs0, pe0, se0;
        int be, ph_tot, exp_ph, exp_words, exp_err;
        c0 = cmd_cnt; p0 = phases; w0 = words; d0 = done_cnt; e0 = err_cnt;
        ge0 = gap_err; gs0 = gap_seen; pe0 = proto_err; se0 = seq_err;
        be = (v.blk == 0) ? 1 : int'(v.blk);
        ph_tot = v.multi ? (int'(v.cnt) + be - 1) / be : int'(v.cnt);
        if (int'(v.errp) < ph_tot) begin
            exp_ph = int'(v.errp);
            exp_words = (v.multi ? imin(exp_ph * be, int'(v.cnt)) : exp_ph) * WPS;
            exp_err = 1;
        end else begin
            exp_ph = ph_tot; exp_words = int'(v.cnt) * WPS; exp_err = 0;
        end
        @(negedge clk_i);
        cfg_cnt = v.cnt; cfg_blk = v.blk; cfg_multi = v.multi;
        cfg_rdy = v.rdy; cfg_errp = v.errp;
        sec_count_i = v.cnt; blk_size_i = v.blk; multi_i = v.multi; start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        wait_end(d0, e0);
        if (v.cnt == 0) begin
            chk("R9", "count 0 writes no command", cmd_cnt - c0, 0);
        end else begin
            chk("R2", "one command write", cmd_cnt - c0, 1);
            chk("R2", "opcode", int'(cmd_byte), v.multi ? 'hC4 : 'h20);
            chk("R7", "settle gaps off target", gap_err - ge0, 0);
            chk("R7", "settle gap observed", (gap_seen - gs0) > 0 ? 1 : 0, 1);
        end
        chk(v.multi ? "R6" : "R5", "data phases", phases - p0, exp_ph);
        chk("R4", "words streamed", words - w0, exp_words);
        chk("R8", "sequence errors", seq_err - se0, 0);
        chk("R3", "data reads outside ready phase", proto_err - pe0, 0);
        chk("R9", "done pulses", done_cnt - d0, 1 - exp_err);
        chk("R3", "error pulses", err_cnt - e0, exp_err);
        if (exp_err == 1) chk("R9", "error pulse delay", err_cyc - last_poll, 1);
        else if (v.cnt != 0) chk("R9", "done pulse delay", done_cyc - last_word_cyc, 1);
        chk("R9", "idle after end", int'(busy_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        chk("R1", "busy in reset", int'(busy_o), 0);
        chk("R1", "bus strobes in reset", int'(tf_rd_o | tf_wr_o), 0);
        chk("R1", "stream and pulses in reset", int'(out_valid_o | done_o | err_o), 0);
        rst_ni = 1'b1;
        repeat (2) @(negedge clk_i);
        chk("R1", "idle after reset", int'(busy_o | tf_rd_o | tf_wr_o), 0);

        for (int i = 0; i < 9; i++) run_vec(VECS[i]);

        // R10: a second start mid-run is ignored
        begin
            int c0, w0, d0, p0;
            c0 = cmd_cnt; w0 = words; d0 = done_cnt; p0 = phases;
            @(negedge clk_i);
            cfg_cnt = 16'd2; cfg_blk = 8'd0; cfg_multi = 1'b0; cfg_rdy = 2'd0; cfg_errp = 8'hFF;
            sec_count_i = 16'd2; blk_size_i = 8'd0; multi_i = 1'b0; start_i = 1'b1;
            @(negedge clk_i);
            start_i = 1'b0;
            repeat (100) @(negedge clk_i);
            sec_count_i = 16'd7; blk_size_i = 8'd4; multi_i = 1'b1; start_i = 1'b1;
            @(negedge clk_i);
            start_i = 1'b0;
            wait_end(d0, err_cnt);
            chk("R10", "commands during busy start", cmd_cnt - c0, 1);
            chk("R10", "opcode kept", int'(cmd_byte), 'h20);
            chk("R10", "words kept", words - w0, 2 * WPS);
            chk("R10", "phases kept", phases - p0, 2);
            chk("R10", "single done", done_cnt - d0, 1);
        end

        finish_run();
    end

endmodule